// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the power-control byte of a small 8-bit microcontroller core and sequences the core between three operating states: Active, Idle and Power-Down. The CPU writes the byte over a simple special-function-register bus. The block then turns the written request into clock-enable outputs for the CPU, for the peripherals and for the main oscillator. It also drives a baud-doubling flag for the serial port and two general-purpose flags for software.

Idle stops only the CPU clock enable, so timers, the serial port and the interrupt logic keep running. Any qualified interrupt brings the core back. Power-Down drops the oscillator enable, which stops every clock enable. Only a hardware reset leaves Power-Down, unless the build-time wake parameter is set. With it set, a qualified request on external interrupt 0 or 1 also brings the core back. The sequencer runs on an always-on clock, so requests are sampled as levels while the oscillator is stopped. The clock gating cells themselves are not part of the block and are modelled only as enables.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The control byte has this layout: bit 7 is the baud-doubling flag, bit 3 is user flag 1, bit 2 is user flag 0, bit 1 is the Power-Down request and bit 0 is the Idle request. Bits 6:4 always read as 0. A write happens when `sfr_sel_i` and `sfr_we_i` are both high at a clock edge while the mode is Active, and `sfr_rdata_o` shows the new byte after that edge.
- R2: `baud_dbl_o` equals bit 7 of the stored byte, and `gp_flags_o` equals bits 3:2.
- R3: After a write in which bit 0 is 1 and bit 1 is 0, `cpu_clk_en_o` is 0 while `per_clk_en_o` and `osc_en_o` stay 1. `mode_o` is 2'b01.
- R4: After a write in which bit 1 is 1, `osc_en_o`, `cpu_clk_en_o` and `per_clk_en_o` are all 0. `mode_o` is 2'b10.
- R5: When bits 1 and 0 are both written as 1 in the same write, Power-Down takes precedence.
- R6: In Idle, the mode returns to Active at the edge where `irq_gen_en_i` is high and some bit of `irq_req_i & irq_en_i` is high. All enables are 1 after that edge. A request whose source enable or global enable is low has no effect.
- R7: In Power-Down, only interrupt sources 0 and 1, qualified in the same way, wake the block, and only when `WAKE_PD_IRQ` is 1. When it is 0, or when the request comes from source 2 or above, the block stays in Power-Down.
- R8: `rst_ni` low asynchronously clears the byte to 0x00 and forces Active with all enables at 1, from any mode.
- R9: An interrupt wake clears bits 1:0 of the byte and keeps bits 7 and 3:2.
- R10: Writes made while the mode is not Active leave the stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| sfr_sel_i | input | 1 | Register bus selects the control byte |
| sfr_we_i | input | 1 | Register bus write strobe |
| sfr_wdata_i | input | 8 | Register bus write data |
| sfr_rdata_o | output | 8 | Stored control byte, unused bits 0 |
| irq_req_i | input | NUM_IRQ | Interrupt request levels, bits 0 and 1 are the external sources |
| irq_en_i | input | NUM_IRQ | Per-source interrupt enables |
| irq_gen_en_i | input | 1 | Global interrupt enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| baud_dbl_o | output | 1 | Serial port baud-doubling flag |
| gp_flags_o | output | 2 | User flags |
| mode_o | output | 2 | 00 Active, 01 Idle, 10 Power-Down |

## Verification
The assertions assume that the bus strobes and interrupt levels are stable around the always-on clock edge. They also assume that the CPU issues writes only while it is running. Writes in other modes are permitted but must be ignored, and one property watches for exactly that. The stimulus changes every input on the falling edge and holds interrupt requests for one full cycle. Reset is applied only as a whole-cycle low pulse, so the step from Idle or Power-Down back to Active is seen at a single rising edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_IDLE   = 2'b01,
    MODE_PDOWN  = 2'b10
  } pmode_e;

  localparam int unsigned BIT_IDL  = 0;
  localparam int unsigned BIT_PD   = 1;
  localparam int unsigned BIT_GP0  = 2;
  localparam int unsigned BIT_GP1  = 3;
  localparam int unsigned BIT_BAUD = 7;
  localparam int unsigned REG_W    = 8;
endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             wake_clr_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             baud_o,
  output logic [1:0]       gp_o,
  output logic             idl_o,
  output logic             pd_o
);
  logic       baud_q, idl_q, pd_q;
  logic [1:0] gp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_q <= 1'b0;
      gp_q   <= 2'b00;
      idl_q  <= 1'b0;
      pd_q   <= 1'b0;
    end else if (wr_en_i) begin
      baud_q <= wdata_i[BIT_BAUD];
      gp_q   <= {wdata_i[BIT_GP1], wdata_i[BIT_GP0]};
      idl_q  <= wdata_i[BIT_IDL];
      pd_q   <= wdata_i[BIT_PD];
    end else if (wake_clr_i) begin
      // wake only drops the mode requests
      idl_q <= 1'b0;
      pd_q  <= 1'b0;
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[BIT_BAUD] = baud_q;
    rdata_o[BIT_GP1]  = gp_q[1];
    rdata_o[BIT_GP0]  = gp_q[0];
    rdata_o[BIT_PD]   = pd_q;
    rdata_o[BIT_IDL]  = idl_q;
  end

  assign baud_o = baud_q;
  assign gp_o   = gp_q;
  assign idl_o  = idl_q;
  assign pd_o   = pd_q;

  a_r9_wake_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_clr_i |=> (baud_q == $past(baud_q)) && (gp_q == $past(gp_q)) && !idl_q && !pd_q);

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rdata_o == ($past(wdata_i) & 8'h8F)));
endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int unsigned NUM_IRQ     = 5,
  parameter bit          WAKE_PD_IRQ = 1'b1
) (
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               irq_gen_en_i,
  output logic               wake_idle_o,
  output logic               wake_pd_o
);
  localparam int unsigned NUM_EXT = (NUM_IRQ < 2) ? NUM_IRQ : 2;

  logic [NUM_IRQ-1:0] qual;
  assign qual        = irq_req_i & irq_en_i & {NUM_IRQ{irq_gen_en_i}};
  assign wake_idle_o = |qual;

  generate
    if (WAKE_PD_IRQ) begin : g_pd_wake
      assign wake_pd_o = |qual[NUM_EXT-1:0];
    end else begin : g_pd_reset_only
      assign wake_pd_o = 1'b0;
    end
  endgenerate

  a_r7_pd_subset: assert final (!wake_pd_o || wake_idle_o);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_en_i,
  input  logic   wr_idl_i,
  input  logic   wr_pd_i,
  input  logic   wake_idle_i,
  input  logic   wake_pd_i,
  output pmode_e mode_o,
  output logic   wake_clr_o,
  output logic   cpu_en_o,
  output logic   per_en_o,
  output logic   osc_en_o
);
  pmode_e mode_q, mode_d;

  always_comb begin
    mode_d     = mode_q;
    wake_clr_o = 1'b0;
    unique case (mode_q)
      MODE_ACTIVE: begin
        if (wr_en_i && wr_pd_i)       mode_d = MODE_PDOWN;  // PD wins
        else if (wr_en_i && wr_idl_i) mode_d = MODE_IDLE;
      end
      MODE_IDLE: if (wake_idle_i) begin
        mode_d     = MODE_ACTIVE;
        wake_clr_o = 1'b1;
      end
      MODE_PDOWN: if (wake_pd_i) begin
        mode_d     = MODE_ACTIVE;
        wake_clr_o = 1'b1;
      end
      default: mode_d = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_ACTIVE;
    else         mode_q <= mode_d;
  end

  assign mode_o   = mode_q;
  assign osc_en_o = (mode_q != MODE_PDOWN);
  assign per_en_o = (mode_q != MODE_PDOWN);
  assign cpu_en_o = (mode_q == MODE_ACTIVE);

  a_r5_pd_precedence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ACTIVE && wr_en_i && wr_pd_i) |=> (mode_q == MODE_PDOWN));

  a_r6_idle_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE && wake_idle_i) |=> (mode_q == MODE_ACTIVE));

  a_r7_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PDOWN && !wake_pd_i) |=> (mode_q == MODE_PDOWN));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 5,
  parameter bit          WAKE_PD_IRQ = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sfr_sel_i,
  input  logic               sfr_we_i,
  input  logic [7:0]         sfr_wdata_i,
  output logic [7:0]         sfr_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               irq_gen_en_i,
  output logic               cpu_clk_en_o,
  output logic               per_clk_en_o,
  output logic               osc_en_o,
  output logic               baud_dbl_o,
  output logic [1:0]         gp_flags_o,
  output logic [1:0]         mode_o
);
  pmode_e mode;
  logic   wr_en, wake_clr, wake_idle, wake_pd, idl, pd;

  assign wr_en = sfr_sel_i && sfr_we_i && (mode == MODE_ACTIVE);

  pwr_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wdata_i    (sfr_wdata_i),
    .wake_clr_i (wake_clr),
    .rdata_o    (sfr_rdata_o),
    .baud_o     (baud_dbl_o),
    .gp_o       (gp_flags_o),
    .idl_o      (idl),
    .pd_o       (pd)
  );

  pwr_wake_qual #(.NUM_IRQ(NUM_IRQ), .WAKE_PD_IRQ(WAKE_PD_IRQ)) u_wake (
    .irq_req_i    (irq_req_i),
    .irq_en_i     (irq_en_i),
    .irq_gen_en_i (irq_gen_en_i),
    .wake_idle_o  (wake_idle),
    .wake_pd_o    (wake_pd)
  );

  pwr_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_idl_i    (sfr_wdata_i[BIT_IDL]),
    .wr_pd_i     (sfr_wdata_i[BIT_PD]),
    .wake_idle_i (wake_idle),
    .wake_pd_i   (wake_pd),
    .mode_o      (mode),
    .wake_clr_o  (wake_clr),
    .cpu_en_o    (cpu_clk_en_o),
    .per_en_o    (per_clk_en_o),
    .osc_en_o    (osc_en_o)
  );

  assign mode_o = mode;

  a_r3_idle_cpu_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && sfr_wdata_i[BIT_IDL] && !sfr_wdata_i[BIT_PD])
      |=> (!cpu_clk_en_o && per_clk_en_o && osc_en_o && idl));

  a_r4_pd_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && sfr_wdata_i[BIT_PD]) |=> (!osc_en_o && !cpu_clk_en_o && !per_clk_en_o && pd));

  a_r10_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_sel_i && sfr_we_i && !cpu_clk_en_o)
      |=> (sfr_rdata_o[7:2] == $past(sfr_rdata_o[7:2])));

  a_r2_flags_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baud_dbl_o == sfr_rdata_o[BIT_BAUD]) && (gp_flags_o == sfr_rdata_o[3:2]));
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NI = 5;
  localparam int  NV = 7;
  // {wdata, rdata after write, {cpu,per,osc} after write}
  localparam logic [18:0] VEC [NV] = '{
    {8'h80, 8'h80, 3'b111},
    {8'h0C, 8'h0C, 3'b111},
    {8'hFC, 8'h8C, 3'b111},
    {8'h05, 8'h05, 3'b011},
    {8'h8A, 8'h8A, 3'b000},
    {8'h03, 8'h03, 3'b000},
    {8'h00, 8'h00, 3'b111}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, gen = 1'b0;
  logic [7:0] wd = '0;
  logic [NI-1:0] req = '0, en = '0;
  logic [7:0] rd0, rd1;
  logic cpu0, per0, osc0, baud0, cpu1, per1, osc1, baud1;
  logic [1:0] gp0, gp1, md0, md1;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NI), .WAKE_PD_IRQ(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sfr_sel_i(sel), .sfr_we_i(we), .sfr_wdata_i(wd),
    .sfr_rdata_o(rd0), .irq_req_i(req), .irq_en_i(en), .irq_gen_en_i(gen),
    .cpu_clk_en_o(cpu0), .per_clk_en_o(per0), .osc_en_o(osc0), .baud_dbl_o(baud0),
    .gp_flags_o(gp0), .mode_o(md0));

  pwr_mode_ctrl #(.NUM_IRQ(NI), .WAKE_PD_IRQ(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sfr_sel_i(sel), .sfr_we_i(we), .sfr_wdata_i(wd),
    .sfr_rdata_o(rd1), .irq_req_i(req), .irq_en_i(en), .irq_gen_en_i(gen),
    .cpu_clk_en_o(cpu1), .per_clk_en_o(per1), .osc_en_o(osc1), .baud_dbl_o(baud1),
    .gp_flags_o(gp1), .mode_o(md1));

  task automatic chk(input string req_s, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; wd = d;
    @(negedge clk); sel = 1'b0; we = 1'b0; wd = '0;
  endtask

  task automatic pulse(input logic [NI-1:0] r);
    @(negedge clk); req = r;
    @(negedge clk); req = '0;
  endtask

  function automatic logic [7:0] en3(input logic c, input logic p, input logic o);
    return {5'b0, c, p, o};
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    // R8 reset state
    chk("R8 rdata", rd0, 8'h00);
    chk("R8 enables", en3(cpu0, per0, osc0), 8'h07);
    chk("R8 mode", {6'b0, md0}, 8'h00);
    rst_n = 1'b1;
    en = '1; gen = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:11]);
      chk("R1 readback", rd0, VEC[i][10:3]);
      chk("R3 R4 R5 enables", en3(cpu0, per0, osc0), {5'b0, VEC[i][2:0]});
      chk("R2 baud", {7'b0, baud0}, {7'b0, VEC[i][10]});
      chk("R2 gp", {6'b0, gp0}, {6'b0, VEC[i][6:5]});
      if (VEC[i][2:0] != 3'b111) begin
        pulse(5'b00001);
        // request drops at this negedge; wake edge already passed
        chk("R6 R7 restore", en3(cpu0, per0, osc0), 8'h07);
        chk("R9 bits kept", rd0, VEC[i][10:3] & 8'hFC);
      end
    end
    // R5 mode code for combined request
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    wr(8'h03);
    chk("R5 mode", {6'b0, md0}, 8'h02);
    pulse(5'b00010);
    chk("R7 src1 wake", {6'b0, md0}, 8'h00);
    chk("R7 no-irq-wake param", {6'b0, md1}, 8'h02);
    // R8 reset leaves power-down
    rst_n = 1'b0; @(negedge clk);
    chk("R8 pd reset", en3(cpu1, per1, osc1), 8'h07);
    chk("R8 pd rdata", rd1, 8'h00);
    rst_n = 1'b1; @(negedge clk);
    // R6 qualification in idle
    wr(8'h01);
    chk("R3 mode", {6'b0, md0}, 8'h01);
    en = 5'b10111;
    pulse(5'b01000);
    chk("R6 source disabled", {6'b0, md0}, 8'h01);
    en = '1; gen = 1'b0;
    pulse(5'b01000);
    chk("R6 global disabled", {6'b0, md0}, 8'h01);
    // R10 write in idle ignored
    wr(8'h8C);
    chk("R10 idle write", rd0, 8'h01);
    gen = 1'b1;
    pulse(5'b01000);
    chk("R6 src3 wake", en3(cpu0, per0, osc0), 8'h07);
    chk("R9 cleared", rd0, 8'h00);
    // R7 non-external source cannot leave power-down
    wr(8'h02);
    pulse(5'b10000);
    chk("R7 src4 ignored", en3(cpu0, per0, osc0), 8'h00);
    wr(8'h80);
    chk("R10 pd write", rd0, 8'h02);
    pulse(5'b00001);
    chk("R7 src0 wake", en3(cpu0, per0, osc0), 8'h07);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule